// File: doc/BRIEF.md
# Power stage fault manager

This block gathers the protection events of a switching power stage and turns them into a high-side gate inhibit and a set of fault reports. It receives asynchronous comparator flags (VCC and VIN above their power-on levels, high-side overcurrent, switch node high while the low side conducts, and junction temperature above the trip level or below the release level). It also receives the PWM tri-state indication and the present gate states. All asynchronous flags pass through two-flop synchronizers before any logic uses them.

A power-on qualification counter holds the stage off until VCC has been good for a programmable number of clock cycles. An overcurrent on the high side blocks the high gate until the controller acknowledges it. The controller does this by holding PWM in tri-state for a programmable delay. A shorted high-side switch latches the inhibit until VCC is lost. Over-temperature uses a two-level hysteresis and only raises its own flag. An active-low summary fault output covers every condition, including supply undervoltage.

Top module: `pstage_fault_mgr`

## Requirements
- R1: After reset `por_ready` is 0. It rises once the synchronized VCC-good flag has been high for QUAL_CYCLES consecutive clock edges: with the input raised, it is still 0 after QUAL_CYCLES+1 edges and is 1 after QUAL_CYCLES+2 edges (two synchronizer edges included). Any loss of VCC clears it, and the count restarts from zero.
- R2: `gh_inhibit` is 1 whenever `por_ready` is 0.
- R3: An overcurrent is taken only while `gh_on` is 1 and VIN is good. Three edges after such a detection, `imon_flag` and `gh_inhibit` are both 1. With `gh_on` at 0 or VIN low, the overcurrent flag has no effect on `imon_flag`.
- R4: An overcurrent fault stays active for as long as `pwm_tri` stays 0. It clears on the ACK_CYCLES-th edge after the first edge that samples `pwm_tri` at 1, provided `pwm_tri` stays 1 throughout. If `pwm_tri` drops earlier, the delay restarts.
- R5: The switch-node-high flag, when seen while `gl_on` is 1, latches `imon_flag` and `gh_inhibit` at 1. PWM tri-state does not clear this latch.
- R6: Over-temperature sets `tmon_flag` when the above-trip flag is seen. The flag holds while neither temperature flag is set and clears only when the below-release flag is seen. It never sets `gh_inhibit`.
- R7: `fault_n` is 0 while any of these holds: an overcurrent or shorted-switch fault, over-temperature, `por_ready` at 0, or synchronized VIN low. Otherwise it is 1.
- R8: During an overcurrent fault (with no other cause present), `fault_n` is the inverse of `imon_flag` in every cycle, and both release on the same edge.
- R9: Loss of VCC clears the overcurrent, shorted-switch and over-temperature states within three edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_ok_a | input | 1 | VCC above power-on level (async) |
| vin_ok_a | input | 1 | VIN above power-on level (async) |
| hs_oc_a | input | 1 | High-side current above limit (async) |
| sw_high_a | input | 1 | Switch node above short threshold (async) |
| temp_over_a | input | 1 | Temperature above trip level (async) |
| temp_under_a | input | 1 | Temperature below release level (async) |
| pwm_tri | input | 1 | PWM input decoded as tri-state |
| gh_on | input | 1 | High gate currently driven on |
| gl_on | input | 1 | Low gate currently driven on |
| por_ready | output | 1 | Power-on qualification complete |
| gh_inhibit | output | 1 | Force the high gate off |
| imon_flag | output | 1 | Drive the current monitor to its fault level |
| tmon_flag | output | 1 | Drive the temperature monitor to its fault level |
| fault_n | output | 1 | Active-low summary fault |

## Verification
The overcurrent path is driven with the current flag raised under three gate/supply combinations: high gate off, VIN low, and both qualifying. Only the last may raise the current flag, which separates correct gating from a detector that ignores its qualifiers. The acknowledge is tried as an unbroken tri-state window, as a window broken one cycle short, and as no window at all. These tell apart a counter that restarts, one that accumulates, and one that never needs the acknowledge. The shorted-switch fault is given the same acknowledge, to show that only VCC loss clears it. Temperature is stepped through set, hold-between-levels and release, to separate hysteresis from a plain follower.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  typedef enum logic [1:0] {
    OC_IDLE = 2'd0,
    OC_HELD = 2'd1,
    OC_ACK  = 2'd2
  } oc_state_t;
endpackage

// File: rtl/pfm_sync.sv
module pfm_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_a,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_a[b]};
    end
    assign q[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/pfm_por_qual.sv
module pfm_por_qual #(
  parameter int QUAL_CYCLES = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_ok,
  output logic ready
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (!vcc_ok) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == LAST) rdy_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready = rdy_q;

  // R1: a VCC drop always removes readiness on the next edge
  p_ready_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok |=> !ready);
endmodule

// File: rtl/pfm_oc_ctl.sv
module pfm_oc_ctl
  import pfm_pkg::*;
#(
  parameter int ACK_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic detect,
  input  logic pwm_tri,
  output logic active
);
  localparam int CW = $clog2(ACK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(ACK_CYCLES - 1);

  oc_state_t     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (clr) begin
      state_d = OC_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        OC_IDLE: if (detect) state_d = OC_HELD;
        OC_HELD: if (pwm_tri) begin
          state_d = OC_ACK;
          cnt_d   = '0;
        end
        OC_ACK: begin
          if (!pwm_tri)          state_d = OC_HELD;
          else if (cnt_q == LAST) state_d = OC_IDLE;
          else                    cnt_d   = cnt_q + 1'b1;
        end
        default: state_d = OC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OC_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign active = (state_q != OC_IDLE);

  // R4: without an acknowledge the fault cannot release
  p_no_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !pwm_tri && !clr) |=> active);
  // R4: release only ever happens out of the acknowledge window
  p_release_in_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !clr && state_q != OC_ACK) |=> active);
endmodule

// File: rtl/pstage_fault_mgr.sv
module pstage_fault_mgr #(
  parameter int QUAL_CYCLES = 12500,
  parameter int ACK_CYCLES  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_ok_a,
  input  logic vin_ok_a,
  input  logic hs_oc_a,
  input  logic sw_high_a,
  input  logic temp_over_a,
  input  logic temp_under_a,
  input  logic pwm_tri,
  input  logic gh_on,
  input  logic gl_on,
  output logic por_ready,
  output logic gh_inhibit,
  output logic imon_flag,
  output logic tmon_flag,
  output logic fault_n
);
  localparam int NFLAGS = 6;

  logic [NFLAGS-1:0] flags_s;
  logic vcc_s, vin_s, oc_s, sw_s, hot_s, cool_s;
  logic rdy, oc_active, oc_detect;
  logic short_q, short_d;
  logic ot_q, ot_d;

  pfm_sync #(.WIDTH(NFLAGS), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_a   ({temp_under_a, temp_over_a, sw_high_a, hs_oc_a, vin_ok_a, vcc_ok_a}),
    .q     (flags_s)
  );
  assign {cool_s, hot_s, sw_s, oc_s, vin_s, vcc_s} = flags_s;

  pfm_por_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_por (
    .clk    (clk),
    .rst_n  (rst_n),
    .vcc_ok (vcc_s),
    .ready  (rdy)
  );

  assign oc_detect = oc_s & gh_on & vin_s & rdy;

  pfm_oc_ctl #(.ACK_CYCLES(ACK_CYCLES)) u_oc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!vcc_s),
    .detect  (oc_detect),
    .pwm_tri (pwm_tri),
    .active  (oc_active)
  );

  always_comb begin
    short_d = short_q;
    ot_d    = ot_q;
    if (!vcc_s) begin
      short_d = 1'b0;
      ot_d    = 1'b0;
    end else begin
      if (sw_s && gl_on && rdy) short_d = 1'b1;
      if (hot_s)                ot_d    = 1'b1;
      else if (cool_s)          ot_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_q <= 1'b0;
      ot_q    <= 1'b0;
    end else begin
      short_q <= short_d;
      ot_q    <= ot_d;
    end
  end

  assign por_ready  = rdy;
  assign gh_inhibit = !rdy || oc_active || short_q;
  assign imon_flag  = oc_active || short_q;
  assign tmon_flag  = ot_q;
  assign fault_n    = !(oc_active || short_q || ot_q || !rdy || !vin_s);

  // R5: the shorted-switch latch holds while VCC stays good
  p_short_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (short_q && vcc_s) |=> short_q);
  // R6: over-temperature holds until the release level is seen
  p_ot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_q && !cool_s && vcc_s) |=> ot_q);
  // R3: no new overcurrent without the high gate on and VIN good
  p_oc_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_active && (!gh_on || !vin_s)) |=> !oc_active);
  // R9: VCC loss wipes every fault state
  p_vcc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_s |=> (!oc_active && !short_q && !ot_q));
endmodule

// File: tb/pstage_fault_mgr_tb_top.sv
module pstage_fault_mgr_tb_top;
  localparam int QUAL = 20;
  localparam int ACK  = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic vcc_ok_a, vin_ok_a, hs_oc_a, sw_high_a, temp_over_a, temp_under_a;
  logic pwm_tri, gh_on, gl_on;
  logic por_ready, gh_inhibit, imon_flag, tmon_flag, fault_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pstage_fault_mgr #(.QUAL_CYCLES(QUAL), .ACK_CYCLES(ACK)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .vcc_ok_a(vcc_ok_a), .vin_ok_a(vin_ok_a), .hs_oc_a(hs_oc_a),
    .sw_high_a(sw_high_a), .temp_over_a(temp_over_a), .temp_under_a(temp_under_a),
    .pwm_tri(pwm_tri), .gh_on(gh_on), .gl_on(gl_on),
    .por_ready(por_ready), .gh_inhibit(gh_inhibit), .imon_flag(imon_flag),
    .tmon_flag(tmon_flag), .fault_n(fault_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic power_up();
    vcc_ok_a = 1'b1;
    vin_ok_a = 1'b1;
    step(QUAL + 4);
  endtask

  task automatic t_reset();
    chk(por_ready, 1'b0, "R1 reset por_ready");
    chk(gh_inhibit, 1'b1, "R2 reset gh_inhibit");
    chk(imon_flag, 1'b0, "R3 reset imon_flag");
    chk(tmon_flag, 1'b0, "R6 reset tmon_flag");
    chk(fault_n, 1'b0, "R7 reset fault_n");
  endtask

  task automatic t_por();
    vin_ok_a = 1'b1;
    vcc_ok_a = 1'b1;
    step(QUAL - 2);
    vcc_ok_a = 1'b0;
    step(3);
    vcc_ok_a = 1'b1;
    step(QUAL + 1);
    chk(por_ready, 1'b0, "R1 ready not early after restart");
    chk(gh_inhibit, 1'b1, "R2 inhibit before ready");
    step(1);
    chk(por_ready, 1'b1, "R1 ready after qualification");
    chk(gh_inhibit, 1'b0, "R2 inhibit released");
    chk(fault_n, 1'b1, "R7 no fault when healthy");
  endtask

  task automatic t_oc_ignored();
    hs_oc_a = 1'b1;
    gh_on   = 1'b0;
    step(5);
    chk(imon_flag, 1'b0, "R3 oc ignored with gate off");
    hs_oc_a  = 1'b0;
    vin_ok_a = 1'b0;
    step(3);
    chk(fault_n, 1'b0, "R7 vin low pulls fault");
    hs_oc_a = 1'b1;
    gh_on   = 1'b1;
    step(4);
    chk(imon_flag, 1'b0, "R3 oc ignored with vin low");
    hs_oc_a  = 1'b0;
    gh_on    = 1'b0;
    vin_ok_a = 1'b1;
    step(3);
    chk(fault_n, 1'b1, "R7 vin restored");
  endtask

  task automatic raise_oc();
    gh_on   = 1'b1;
    hs_oc_a = 1'b1;
    step(3);
    hs_oc_a = 1'b0;
    gh_on   = 1'b0;
  endtask

  task automatic t_oc_ack();
    raise_oc();
    chk(imon_flag, 1'b1, "R3 oc raises imon_flag");
    chk(gh_inhibit, 1'b1, "R3 oc inhibits high gate");
    step(20);
    chk(imon_flag, 1'b1, "R4 no ack keeps fault");
    chk(fault_n, ~imon_flag, "R8 fault_n tracks imon");
    pwm_tri = 1'b1;
    step(ACK);
    chk(imon_flag, 1'b1, "R4 still held before delay");
    chk(fault_n, 1'b0, "R8 fault_n held with imon");
    step(1);
    chk(imon_flag, 1'b0, "R4 cleared after ack delay");
    chk(fault_n, 1'b1, "R8 fault_n releases with imon");
    pwm_tri = 1'b0;
    step(2);
  endtask

  task automatic t_oc_broken_ack();
    raise_oc();
    pwm_tri = 1'b1;
    step(ACK - 1);
    pwm_tri = 1'b0;
    step(1);
    pwm_tri = 1'b1;
    step(ACK);
    chk(imon_flag, 1'b1, "R4 broken ack restarts delay");
    step(1);
    chk(imon_flag, 1'b0, "R4 clears after full window");
    pwm_tri = 1'b0;
    step(2);
  endtask

  task automatic t_short();
    gl_on     = 1'b1;
    sw_high_a = 1'b1;
    step(3);
    chk(imon_flag, 1'b1, "R5 short raises imon_flag");
    chk(gh_inhibit, 1'b1, "R5 short inhibits high gate");
    sw_high_a = 1'b0;
    gl_on     = 1'b0;
    pwm_tri   = 1'b1;
    step(ACK + 5);
    chk(imon_flag, 1'b1, "R5 tri-state does not clear short");
    chk(gh_inhibit, 1'b1, "R5 inhibit stays latched");
    pwm_tri  = 1'b0;
    vcc_ok_a = 1'b0;
    step(3);
    chk(imon_flag, 1'b0, "R9 vcc loss clears short");
    chk(por_ready, 1'b0, "R1 vcc loss drops ready");
    power_up();
    chk(imon_flag, 1'b0, "R9 short stays clear after repower");
    chk(gh_inhibit, 1'b0, "R2 inhibit free after repower");
  endtask

  task automatic t_ot();
    temp_over_a = 1'b1;
    step(3);
    chk(tmon_flag, 1'b1, "R6 over-temperature sets flag");
    chk(fault_n, 1'b0, "R7 over-temperature pulls fault");
    chk(gh_inhibit, 1'b0, "R6 over-temperature leaves gating");
    temp_over_a = 1'b0;
    step(5);
    chk(tmon_flag, 1'b1, "R6 flag holds between levels");
    temp_under_a = 1'b1;
    step(3);
    chk(tmon_flag, 1'b0, "R6 flag clears below release");
    chk(fault_n, 1'b1, "R7 fault released after cool");
    temp_under_a = 1'b0;
    temp_over_a  = 1'b1;
    step(3);
    temp_over_a = 1'b0;
    vcc_ok_a    = 1'b0;
    step(3);
    chk(tmon_flag, 1'b0, "R9 vcc loss clears over-temperature");
    power_up();
  endtask

  initial begin
    rst_n = 1'b0;
    vcc_ok_a = 1'b0; vin_ok_a = 1'b0; hs_oc_a = 1'b0; sw_high_a = 1'b0;
    temp_over_a = 1'b0; temp_under_a = 1'b0;
    pwm_tri = 1'b0; gh_on = 1'b0; gl_on = 1'b0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_por();
    t_oc_ignored();
    t_oc_ack();
    t_oc_broken_ack();
    t_short();
    t_ot();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule